// File: doc/BRIEF.md
# UART Receive Buffer with Per-Frame Status

This block sits between a UART deserializer and the register bus. Completed frames go into a two-entry circular FIFO. Each entry keeps the data byte together with its ninth bit, its framing-error flag and its overrun flag. Software reads the status of the head entry first and then pops it by reading the data.

When both FIFO entries are occupied, a newly completed frame is parked in a hold stage that stands for the receive shift register. That frame waits there until a FIFO slot frees up. The parked frame is discarded only if the deserializer reports a new start bit while the FIFO is still full. The next frame that enters the FIFO after such a loss carries the overrun flag. Deasserting the receiver enable empties the whole buffer.

Top module: `rxbuf_top`

## Requirements
- R1: After a synchronous reset, `rx_done` is 0 and the buffer holds no frames.
- R2: Frames entering the FIFO leave it in arrival order. The FIFO holds at most DEPTH (default 2) entries.
- R3: A read strobe while `rx_done` is 1 removes exactly one entry. A read strobe while `rx_done` is 0 leaves the buffer unchanged, and a frame pushed afterwards is the head.
- R4: `rd_bit9`, `rd_ferr` and `rd_ovr` show the flags stored with the head entry. The ninth bit and the framing error come from the `frm_bit9` and `frm_ferr` values that accompanied that frame's `frm_valid` strobe.
- R5: A frame that completes while the FIFO is full is held as a third level. One clock after a FIFO entry is freed, the held frame enters the FIFO with its own status, behind the older entries.
- R6: A `start_det` pulse while a frame is held and the FIFO is full discards the held frame. The next frame that enters the FIFO after that has `rd_ovr` = 1, and the frames that were already in the FIFO keep `rd_ovr` = 0.
- R7: A `start_det` pulse when no frame is held discards nothing and sets no overrun flag.
- R8: While `rx_en` is 0, the FIFO entries, the held frame and any pending overrun are all cleared, so `rx_done` is 0 one clock later.
- R9: `rx_done` is 1 exactly when the FIFO holds at least one entry. A frame is visible at the head one clock after its `frm_valid` strobe when the FIFO has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | DATA_W | Data bits of the completed frame |
| frm_bit9 | input | 1 | Ninth data bit of the completed frame |
| frm_ferr | input | 1 | Framing error of the completed frame |
| start_det | input | 1 | One-cycle strobe: a start bit has been detected |
| rd_stb | input | 1 | Bus read of the data register (pops the head) |
| rd_data | output | DATA_W | Head entry data |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing error |
| rd_ovr | output | 1 | Head entry overrun flag |
| rx_done | output | 1 | FIFO holds at least one entry |

## Verification
The assertions take for granted that `frm_valid` and `start_det` are single-cycle strobes and that the loss check is meaningful only on cycles without a simultaneous frame completion, which a real deserializer cannot produce since a frame must start before it ends. The stimulus pulses each strobe for one clock, never raises `frm_valid` and `start_det` together, and leaves an idle cycle after each read. That idle cycle gives a held frame the clock it needs to move into the FIFO before the head is checked.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  // Entry layout above the data field: ninth bit, overrun, framing error.
  localparam int OFS_BIT9 = 0;
  localparam int OFS_OVR  = 1;
  localparam int OFS_FERR = 2;
  localparam int STAT_W   = 3;
endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 8,
  localparam int ENT_W = DATA_W + STAT_W,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             pop_ok;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign pop_ok = pop && !empty;
  assign head   = mem[rp];

  // Storage without reset so it maps onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)   wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> empty);
endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ENT_W = DATA_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              frm_ferr,
  input  logic              start_det,
  input  logic              fifo_full,
  output logic              push,
  output logic [ENT_W-1:0]  push_ent,
  output logic              hold_v,
  output logic              ovr_pend
);
  logic [ENT_W-1:0] hold_q, frm_ent;
  logic move, direct, lose, clobber;

  always_comb begin
    frm_ent = '0;
    frm_ent[DATA_W-1:0]         = frm_data;
    frm_ent[DATA_W + OFS_BIT9]  = frm_bit9;
    frm_ent[DATA_W + OFS_FERR]  = frm_ferr;
    move    = hold_v && !fifo_full;
    direct  = frm_valid && !hold_v && !fifo_full;
    lose    = start_det && hold_v && fifo_full;
    clobber = frm_valid && hold_v && fifo_full;
    push    = en && (move || direct);
    push_ent = move ? hold_q : frm_ent;
    push_ent[DATA_W + OFS_OVR] = ovr_pend;
  end

  always_ff @(posedge clk) begin
    if (frm_valid && !direct) hold_q <= frm_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_v   <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (frm_valid && !direct) hold_v <= 1'b1;
      else if (move || lose)    hold_v <= 1'b0;
      if (lose || clobber) ovr_pend <= 1'b1;
      else if (push)       ovr_pend <= 1'b0;
    end
  end

  assert_no_loss_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !hold_v && !ovr_pend && !frm_valid) |=> !ovr_pend);
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_bit9,
  input  logic              frm_ferr,
  input  logic              start_det,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              rd_ovr,
  output logic              rx_done
);
  localparam int ENT_W = DATA_W + STAT_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push, hold_v, ovr_pend, full, empty;
  logic [ENT_W-1:0] push_ent, head;
  logic [CNT_W-1:0] count;

  rxbuf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk, .rst, .en(rx_en), .frm_valid, .frm_data, .frm_bit9, .frm_ferr,
    .start_det, .fifo_full(full), .push, .push_ent, .hold_v, .ovr_pend
  );

  rxbuf_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk, .rst, .flush(!rx_en), .push, .push_ent, .pop(rd_stb && rx_en),
    .head, .count, .full, .empty
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_bit9 = !empty && head[DATA_W + OFS_BIT9];
  assign rd_ferr = !empty && head[DATA_W + OFS_FERR];
  assign rd_ovr  = !empty && head[DATA_W + OFS_OVR];
  assign rx_done = !empty;

  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_done && !hold_v && !ovr_pend));
  assert_loss_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_en && start_det && hold_v && full && !frm_valid) |=> (ovr_pend && !hold_v));
  assert_hold_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_en && hold_v && !full && !rd_stb) |=> (count == $past(count) + 1'b1));
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> !rx_done);
endmodule

// File: tb/rxbuf_top_tb.sv
`timescale 1ns/1ps
module rxbuf_top_tb;
  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b1;
  logic frm_valid = 1'b0, frm_bit9 = 1'b0, frm_ferr = 1'b0, start_det = 1'b0, rd_stb = 1'b0;
  logic [7:0] frm_data = '0;
  logic [7:0] rd_data;
  logic rd_bit9, rd_ferr, rd_ovr, rx_done;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  rxbuf_top #(.DEPTH(2), .DATA_W(8)) u_dut (
    .clk, .rst, .rx_en, .frm_valid, .frm_data, .frm_bit9, .frm_ferr,
    .start_det, .rd_stb, .rd_data, .rd_bit9, .rd_ferr, .rd_ovr, .rx_done
  );

  function automatic logic [7:0] fd(input int i); return 8'(8'h3C + 7 * i); endfunction
  function automatic logic fb9(input int i); return i[0]; endfunction
  function automatic logic ffe(input int i); return i[1]; endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, return at the next falling edge.
  task automatic tick(input logic fv, input int idx, input logic sd, input logic rd);
    frm_valid = fv; frm_data = fd(idx); frm_bit9 = fb9(idx); frm_ferr = ffe(idx);
    start_det = sd; rd_stb = rd;
    @(negedge clk);
    frm_valid = 1'b0; start_det = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic push(input int idx); tick(1'b1, idx, 1'b0, 1'b0); endtask
  task automatic idle(); tick(1'b0, 0, 1'b0, 1'b0); endtask
  task automatic rd_idle(); tick(1'b0, 0, 1'b0, 1'b1); idle(); endtask

  task automatic check_head(input string req, input int idx, input logic ovr);
    check({req, " rx_done"}, int'(rx_done), 1);
    check({req, " data"}, int'(rd_data), int'(fd(idx)));
    check({req, " bit9"}, int'(rd_bit9), int'(fb9(idx)));
    check({req, " ferr"}, int'(rd_ferr), int'(ffe(idx)));
    check({req, " ovr"}, int'(rd_ovr), int'(ovr));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset rx_done", int'(rx_done), 0);

    // R9 + R4: single frame visible one clock after its strobe
    push(3);
    check_head("R9/R4 single", 3, 1'b0);
    tick(1'b0, 0, 1'b0, 1'b1);
    check("R3 pop to empty", int'(rx_done), 0);

    // R3: read while empty changes nothing
    tick(1'b0, 0, 1'b0, 1'b1);
    check("R3 empty read", int'(rx_done), 0);
    push(4);
    check_head("R3 after empty read", 4, 1'b0);
    rd_idle();
    check("R3 drained", int'(rx_done), 0);

    // R2 / R5: sweep fill levels 1..3 (3 uses the hold stage)
    for (int k = 1; k <= 3; k++) begin
      for (int i = 0; i < k; i++) push(10 * k + i);
      idle();
      for (int j = 0; j < k; j++) begin
        check_head(k == 3 ? "R5 hold order" : "R2 order", 10 * k + j, 1'b0);
        rd_idle();
      end
      check("R2 sweep empty", int'(rx_done), 0);
    end

    // R6: loss of the held frame, overrun attaches to next entering frame
    push(40); push(41); push(42);
    tick(1'b0, 0, 1'b1, 1'b0);
    push(43);
    idle();
    check_head("R6 old head", 40, 1'b0);
    rd_idle();
    check_head("R6 second old", 41, 1'b0);
    rd_idle();
    check_head("R6 flagged frame", 43, 1'b1);
    rd_idle();
    check("R6 drained", int'(rx_done), 0);

    // R7: start bit with no held frame
    push(50);
    tick(1'b0, 0, 1'b1, 1'b0);
    push(51);
    tick(1'b0, 0, 1'b1, 1'b0);
    push(52);
    idle();
    check_head("R7 first", 50, 1'b0);
    rd_idle();
    check_head("R7 second", 51, 1'b0);
    rd_idle();
    check_head("R7 held no loss", 52, 1'b0);
    rd_idle();
    check("R7 drained", int'(rx_done), 0);

    // R8: flush with a held frame and a pending overrun
    push(60); push(61); push(62);
    tick(1'b0, 0, 1'b1, 1'b0);
    rx_en = 1'b0;
    idle();
    check("R8 flush rx_done", int'(rx_done), 0);
    rx_en = 1'b1;
    idle();
    check("R8 stays empty", int'(rx_done), 0);
    push(63);
    check_head("R8 after flush", 63, 1'b0);
    rd_idle();
    check("R8 drained", int'(rx_done), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule